// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block sequences the conversions of an analog-to-digital converter. It decides when a conversion begins, when one that is running is thrown away and begun again, when it is abandoned, and when the block goes back to waiting for a new trigger. A conversion can be started in three ways:

- by software, through the enable bit;
- by a chosen edge on an external trigger pin;
- by a pulse from a timer.

The analog core is not part of the block. A cycle counter stands in for it and sets how long each conversion lasts. The counter runs long in normal mode and short in high-speed mode.

The surrounding register file supplies several inputs:

- the enable bit;
- the selection of software or hardware triggering, and of pin or timer within hardware triggering;
- the speed code;
- the pin edge mode;
- a strobe that pulses whenever any control register is written.

What a trigger or a register write does during a running conversion depends on two things: the speed mode and the trigger source. In normal mode such events are not allowed. They are ignored and recorded in a sticky error flag, which is cleared through a dedicated input.

Top module: `adc_trig_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `start_pulse`, `done_pulse` and `proto_err` are all 0.
- R2: In software mode (`hw_sel`=0), setting `enable` starts a conversion at the next clock edge. At that edge `start_pulse` is 1 for one cycle and `busy` rises. The conversion length is 16 cycles when `speed_mode` is 00 and 8 cycles for codes 01, 10 and 11. That length is the number of cycles from the `start_pulse` cycle to the `done_pulse` cycle.
- R3: In software mode, a conversion that completes while `enable` is still 1 is followed at once by another. `done_pulse` and `start_pulse` are 1 in the same cycle, and `busy` stays 1.
- R4: In hardware mode (`hw_sel`=1), setting `enable` starts nothing. With `tmr_sel`=1, a one-cycle `timer_evt` starts a conversion at the edge that samples it. When that conversion completes, `done_pulse` is 1, `busy` is 0 and the block waits for the next trigger.
- R5: With `hw_sel`=1 and `tmr_sel`=0, `ext_trig` is triggered on the edge chosen by `edge_sel`: 00 never, 01 falling, 10 rising, 11 both. The pin passes through two synchronizer flops. `start_pulse` appears on the third clock edge that samples the new pin level.
- R6: In high-speed mode with hardware triggering, a trigger during a conversion restarts it. `start_pulse` is 1, no `done_pulse` is issued, and a full conversion follows from the restart.
- R7: In high-speed software mode, a `cfg_wr` pulse during a conversion restarts it. `start_pulse` is 1 and a full conversion follows.
- R8: In high-speed hardware mode, a `cfg_wr` pulse during a conversion abandons it. `busy` falls at that edge, no `done_pulse` is issued, and the block waits for a new trigger.
- R9: In normal mode (`speed_mode`=00), a trigger or a `cfg_wr` pulse during a conversion does not disturb it; the conversion completes at its original time. The event sets `proto_err`, which stays 1 until `err_clr` is pulsed.
- R10: Clearing `enable` stops the block at the next edge. `busy` falls and no `done_pulse` is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| enable | input | 1 | Converter enable |
| hw_sel | input | 1 | 0 = software triggering, 1 = hardware triggering |
| tmr_sel | input | 1 | In hardware mode: 0 = external pin, 1 = timer event |
| speed_mode | input | 2 | 00 normal, other codes high-speed |
| edge_sel | input | 2 | Pin edge: 00 none, 01 falling, 10 rising, 11 both |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| timer_evt | input | 1 | One-cycle timer event |
| cfg_wr | input | 1 | Pulses when any control register is written |
| err_clr | input | 1 | Clears the protocol error flag |
| busy | output | 1 | Conversion in progress |
| start_pulse | output | 1 | One cycle at each conversion start or restart |
| done_pulse | output | 1 | One cycle after a conversion completes |
| proto_err | output | 1 | Sticky flag for an event that normal mode does not allow |

## Verification
Completion of a conversion and the start of the next one share a cycle in repeating software mode. The bench provokes this by holding `enable` across an 8-cycle high-speed conversion. At the completion tick it requires `done_pulse`, `start_pulse` and `busy` to be 1 together, with no idle cycle in between. A restart by trigger or write also falls inside a running count. That case is judged by the absence of `done_pulse` until exactly one full conversion length after the restart tick.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;

  // Sequencer states
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_t;

  // Pin edge modes
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  // Any non-zero speed code selects the short conversion
  function automatic logic speed_is_fast(input logic [1:0] code);
    return code != 2'b00;
  endfunction

endpackage

// File: rtl/adc_trig_edge.sv
`timescale 1ns/1ps
module adc_trig_edge
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;
  logic                   rise;
  logic                   fall;

  // Synchronizer chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[gi] <= 1'b0;
          else        sync_q[gi] <= sync_q[gi-1];
        end
      end
    end
  endgenerate

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (edge_mode_t'(edge_sel))
      EDGE_NONE: hit = 1'b0;
      EDGE_FALL: hit = fall;
      EDGE_RISE: hit = rise;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/adc_trig_timer.sv
`timescale 1ns/1ps
module adc_trig_timer #(
  parameter int NORM_CYCLES = 16,
  parameter int FAST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,      // begin or restart a conversion
  input  logic fast_in,   // speed to latch at load
  input  logic run,       // conversion in progress
  output logic last,      // final cycle of the conversion
  output logic cur_fast   // speed latched for this conversion
);

  localparam int MAX_CYC = (NORM_CYCLES > FAST_CYCLES) ? NORM_CYCLES : FAST_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] NORM_LAST = CW'(NORM_CYCLES - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fast_q, fast_d;
  logic          cnt_en;

  assign cnt_en = load | run;

  always_comb begin
    cnt_d  = cnt_q;
    fast_d = fast_q;
    if (load) begin
      cnt_d  = '0;
      fast_d = fast_in;
    end else if (run) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      fast_q <= fast_d;
    end
  end

  assign last     = cnt_q == (fast_q ? FAST_LAST : NORM_LAST);
  assign cur_fast = fast_q;

endmodule

// File: rtl/adc_trig_seq.sv
`timescale 1ns/1ps
module adc_trig_seq
  import adc_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hw_sel,
  input  logic trig_evt,   // already qualified by source and edge
  input  logic cfg_wr,
  input  logic last,
  input  logic cur_fast,
  output logic tmr_load,
  output logic tmr_run,
  output logic err_set,
  output logic busy,
  output logic start_pulse,
  output logic done_pulse
);

  seq_state_t state_q, state_d;
  logic       start_q, start_d;
  logic       done_q, done_d;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    start_d  = 1'b0;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    err_set  = 1'b0;
    if (!enable) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (hw_sel) begin
            state_d = ST_ARMED;
          end else begin
            state_d  = ST_RUN;
            tmr_load = 1'b1;
            start_d  = 1'b1;
          end
        end
        ST_ARMED: begin
          if (!hw_sel || trig_evt) begin
            state_d  = ST_RUN;
            tmr_load = 1'b1;
            start_d  = 1'b1;
          end
        end
        ST_RUN: begin
          if (cur_fast) begin
            if (trig_evt) begin
              tmr_load = 1'b1;
              start_d  = 1'b1;
            end else if (cfg_wr) begin
              if (hw_sel) begin
                state_d = ST_ARMED;
              end else begin
                tmr_load = 1'b1;
                start_d  = 1'b1;
              end
            end else if (last) begin
              done_d = 1'b1;
              if (hw_sel) begin
                state_d = ST_ARMED;
              end else begin
                tmr_load = 1'b1;
                start_d  = 1'b1;
              end
            end
          end else begin
            err_set = trig_evt | cfg_wr;
            if (last) begin
              done_d = 1'b1;
              if (hw_sel) begin
                state_d = ST_ARMED;
              end else begin
                tmr_load = 1'b1;
                start_d  = 1'b1;
              end
            end
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign tmr_run     = (state_q == ST_RUN);
  assign busy        = (state_q == ST_RUN);
  assign start_pulse = start_q;
  assign done_pulse  = done_q;

endmodule

// File: rtl/adc_trig_ctrl.sv
`timescale 1ns/1ps
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int NORM_CYCLES = 16,
  parameter int FAST_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       hw_sel,
  input  logic       tmr_sel,
  input  logic [1:0] speed_mode,
  input  logic [1:0] edge_sel,
  input  logic       ext_trig,
  input  logic       timer_evt,
  input  logic       cfg_wr,
  input  logic       err_clr,
  output logic       busy,
  output logic       start_pulse,
  output logic       done_pulse,
  output logic       proto_err
);

  logic ext_hit;
  logic trig_evt;
  logic tmr_load;
  logic tmr_run;
  logic tmr_last;
  logic cur_fast;
  logic err_set;
  logic err_q, err_d;

  adc_trig_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_trig),
    .edge_sel (edge_sel),
    .hit      (ext_hit)
  );

  // Only the selected hardware source counts as a trigger
  assign trig_evt = enable & hw_sel & (tmr_sel ? timer_evt : ext_hit);

  adc_trig_timer #(
    .NORM_CYCLES (NORM_CYCLES),
    .FAST_CYCLES (FAST_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .fast_in  (speed_is_fast(speed_mode)),
    .run      (tmr_run),
    .last     (tmr_last),
    .cur_fast (cur_fast)
  );

  adc_trig_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hw_sel      (hw_sel),
    .trig_evt    (trig_evt),
    .cfg_wr      (cfg_wr),
    .last        (tmr_last),
    .cur_fast    (cur_fast),
    .tmr_load    (tmr_load),
    .tmr_run     (tmr_run),
    .err_set     (err_set),
    .busy        (busy),
    .start_pulse (start_pulse),
    .done_pulse  (done_pulse)
  );

  // Sticky error: a new violation wins over a clear in the same cycle
  always_comb begin
    err_d = err_q;
    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign proto_err = err_q;

endmodule

// File: rtl/adc_trig_ctrl_chk.sv
`timescale 1ns/1ps
module adc_trig_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic hw_sel,
  input logic err_clr,
  input logic busy,
  input logic start_pulse,
  input logic done_pulse,
  input logic proto_err
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);

  // R3
  sw_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && !$past(hw_sel)) |-> (start_pulse && busy));

  // R4
  hw_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && $past(hw_sel)) |-> !busy);

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> $past(busy));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !err_clr) |=> proto_err);

  // R10
  stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !done_pulse));

  // R10
  done_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(enable) && $past(busy)));

endmodule

bind adc_trig_ctrl adc_trig_ctrl_chk u_chk (.*);

// File: tb/adc_trig_ctrl_test.sv
`timescale 1ns/1ps
module adc_trig_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 7;
  // {hw_sel, tmr_sel, speed_mode[1:0], expected length[5:0]}
  localparam logic [9:0] CFG_TAB [NTAB] = '{
    {1'b0, 1'b0, 2'b00, 6'd16},
    {1'b0, 1'b0, 2'b01, 6'd8},
    {1'b0, 1'b0, 2'b10, 6'd8},
    {1'b0, 1'b0, 2'b11, 6'd8},
    {1'b1, 1'b1, 2'b01, 6'd8},
    {1'b1, 1'b1, 2'b10, 6'd8},
    {1'b1, 1'b1, 2'b00, 6'd16}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable, hw_sel, tmr_sel, ext_trig, timer_evt, cfg_wr, err_clr;
  logic [1:0] speed_mode, edge_sel;
  logic       busy, start_pulse, done_pulse, proto_err;

  int  checks   = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .hw_sel      (hw_sel),
    .tmr_sel     (tmr_sel),
    .speed_mode  (speed_mode),
    .edge_sel    (edge_sel),
    .ext_trig    (ext_trig),
    .timer_evt   (timer_evt),
    .cfg_wr      (cfg_wr),
    .err_clr     (err_clr),
    .busy        (busy),
    .start_pulse (start_pulse),
    .done_pulse  (done_pulse),
    .proto_err   (proto_err)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Ticks until done_pulse; returns the number of ticks taken
  task automatic measure(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!done_pulse && n < 40);
  endtask

  task automatic observe(input int cycles, output int starts, output int dones, output int busys);
    starts = 0; dones = 0; busys = 0;
    for (int k = 0; k < cycles; k++) begin
      tick();
      starts += int'(start_pulse);
      dones  += int'(done_pulse);
      busys  += int'(busy);
    end
  endtask

  task automatic timer_pulse();
    timer_evt = 1'b1;
    tick();
    timer_evt = 1'b0;
  endtask

  // Pin change seen as start on the third tick, then one full fast conversion
  task automatic pin_start(input logic lvl, input string req);
    int n;
    ext_trig = lvl;
    tick();
    chk(req, "start tick1", int'(start_pulse), 0);
    tick();
    chk(req, "start tick2", int'(start_pulse), 0);
    tick();
    chk(req, "start tick3", int'(start_pulse), 1);
    measure(n);
    chk(req, "ext conv length", n, 8);
  endtask

  task automatic stop_all();
    enable = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n, s, d, b;
    rst_n = 1'b0; enable = 1'b0; hw_sel = 1'b0; tmr_sel = 1'b0;
    speed_mode = 2'b00; edge_sel = 2'b00; ext_trig = 1'b0;
    timer_evt = 1'b0; cfg_wr = 1'b0; err_clr = 1'b0;
    repeat (3) tick();
    // R1 reset state
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "start in reset", int'(start_pulse), 0);
    chk("R1", "done in reset", int'(done_pulse), 0);
    chk("R1", "err in reset", int'(proto_err), 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "idle after reset", int'(busy | start_pulse | done_pulse | proto_err), 0);

    // Table: conversion length per source and speed (R2, R3, R4)
    for (int i = 0; i < NTAB; i++) begin
      logic [9:0] e;
      e = CFG_TAB[i];
      stop_all();
      hw_sel = e[9]; tmr_sel = e[8]; speed_mode = e[7:6];
      enable = 1'b1;
      if (e[9]) begin
        repeat (3) tick();
        timer_pulse();
      end else begin
        tick();
      end
      chk(e[9] ? "R4" : "R2", "start at trigger", int'(start_pulse & busy), 1);
      measure(n);
      chk(e[9] ? "R4" : "R2", "conversion length", n, int'(e[5:0]));
      if (e[9]) chk("R4", "busy after done", int'(busy), 0);
      else      chk("R3", "back-to-back start", int'(start_pulse & busy & done_pulse), 1);
    end
    stop_all();

    // R4 enable alone starts nothing in hardware mode
    hw_sel = 1'b1; tmr_sel = 1'b1; speed_mode = 2'b01; enable = 1'b1;
    observe(6, s, d, b);
    chk("R4", "starts without trigger", s, 0);
    chk("R4", "busy without trigger", b, 0);

    // R6 fast timer retrigger restarts
    timer_pulse();
    repeat (3) tick();
    timer_pulse();
    chk("R6", "restart start pulse", int'(start_pulse), 1);
    chk("R6", "no done at restart", int'(done_pulse), 0);
    measure(n);
    chk("R6", "length after restart", n, 8);

    // R8 fast hardware write abandons
    timer_pulse();
    repeat (2) tick();
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
    chk("R8", "busy after write", int'(busy), 0);
    chk("R8", "done after write", int'(done_pulse), 0);
    observe(10, s, d, b);
    chk("R8", "activity while waiting", s + d + b, 0);
    timer_pulse();
    chk("R8", "rearmed start", int'(start_pulse), 1);
    stop_all();

    // R5 external pin edges, fast mode
    tmr_sel = 1'b0; edge_sel = 2'b10; enable = 1'b1;
    repeat (3) tick();
    pin_start(1'b1, "R5");
    ext_trig = 1'b0;
    observe(6, s, d, b);
    chk("R5", "fall ignored in rise mode", s, 0);
    edge_sel = 2'b01;
    ext_trig = 1'b1;
    observe(6, s, d, b);
    chk("R5", "rise ignored in fall mode", s, 0);
    pin_start(1'b0, "R5");
    edge_sel = 2'b00;
    ext_trig = 1'b1;
    observe(6, s, d, b);
    ext_trig = 1'b0;
    observe(6, s, b, d);
    chk("R5", "no-edge mode starts", s, 0);
    edge_sel = 2'b11;
    pin_start(1'b1, "R5");
    pin_start(1'b0, "R5");
    stop_all();

    // R7 fast software write restarts
    hw_sel = 1'b0; speed_mode = 2'b10; enable = 1'b1;
    tick();
    repeat (3) tick();
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
    chk("R7", "restart on write", int'(start_pulse & busy), 1);
    measure(n);
    chk("R7", "length after write", n, 8);
    stop_all();

    // R9 normal mode software write ignored, flag set
    speed_mode = 2'b00; enable = 1'b1;
    tick();
    chk("R9", "err before violation", int'(proto_err), 0);
    repeat (4) tick();
    cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
    chk("R9", "no restart in normal", int'(start_pulse), 0);
    chk("R9", "err set", int'(proto_err), 1);
    measure(n);
    chk("R9", "original completion", n, 11);
    stop_all();
    chk("R9", "err sticky", int'(proto_err), 1);
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    chk("R9", "err cleared", int'(proto_err), 0);

    // R9 normal mode timer retrigger ignored
    hw_sel = 1'b1; tmr_sel = 1'b1; enable = 1'b1;
    repeat (3) tick();
    timer_pulse();
    repeat (2) tick();
    timer_pulse();
    chk("R9", "no timer restart", int'(start_pulse), 0);
    chk("R9", "err from trigger", int'(proto_err), 1);
    measure(n);
    chk("R9", "timer original completion", n, 13);
    stop_all();
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;

    // R10 disable mid conversion
    hw_sel = 1'b0; speed_mode = 2'b01; enable = 1'b1;
    tick();
    repeat (3) tick();
    enable = 1'b0;
    tick();
    chk("R10", "busy after disable", int'(busy), 0);
    chk("R10", "done after disable", int'(done_pulse), 0);
    observe(10, s, d, b);
    chk("R10", "activity after disable", s + d + b, 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule